// File: doc/BRIEF.md
# Per-Clock Third-Order Moving-Sum Bitstream Filter

This block turns a one-bit oversampled modulator stream into a multi-bit sample on every clock, with no decimation. Three boxcar stages are chained. Each stage holds a delay line of its recent inputs. On every clock it updates a running sum by adding the value that enters and removing the value that drops out of the active window. The combined response is that of a third-order sinc filter that slides by one bit per clock. A downstream consumer can therefore take a filtered value in any cycle it chooses.

The window length is selectable: 8 or 16 taps, applied to all three stages at once. A change of selection empties every delay line and running sum. The output is then marked not valid until enough bits have entered to fill all three windows. The first stage can count up to 16, which needs an extra bit. An optional clamp turns that one count into 15 before it reaches the second stage. Because the clamped value is what enters the second delay line, the later running sums stay consistent with their own windows.

Top module: `mavg_bitstream_filter`

## Requirements
- R1: While reset is held and immediately after it, `sample_o` is 0 and `valid_o` is 0. Reset leaves the short (8-tap) length stored.
- R2: Take b(k) as the bit captured at the k-th clock edge after the last clear, with b = 0 before that. Let L be the window length and s1(p) the sum of b(p-L+1)..b(p). Let f be the clamp. After edge k, `sample_o` equals the sum over j,i in 0..L-1 of f(s1(k-2-j-i)).
- R3: With `len_sel` = 1 (16 taps), the clamp off and a steady all-ones input, the sample settles at the full-scale value 4096.
- R4: With `sat_en` = 1, a first-stage count of 16 is replaced by 15. The all-ones full-scale value at 16 taps is then 3840.
- R5: With `len_sel` = 0 (8 taps), a steady all-ones input settles at 512.
- R6: An edge at which `len_sel` differs from the stored length clears all delay lines and sums and does not capture a bit. Right after that edge, `sample_o` is 0 and `valid_o` is 0.
- R7: `valid_o` first rises after the 3L-th capturing edge following a clear (edge 24 for 8 taps, 48 for 16).
- R8: A new sample is produced on every clock. No edge is skipped.
- R9: The clamp has no effect when no first-stage count reaches 16. The output then matches the unclamped value.
- R10: Once `valid_o` is high, it stays high for as long as `len_sel` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_i | input | 1 | Modulator bitstream, one bit per clock |
| len_sel | input | 1 | Window length: 0 = 8 taps, 1 = 16 taps |
| sat_en | input | 1 | 1 = clamp a first-stage count of 16 to 15 |
| sample_o | output | 13 | Filtered sample, updated every clock |
| valid_o | output | 1 | High once all three windows hold real bits since the last clear |

## Verification
The hardest case to reach is a clamped count inside a filled pipeline. To get there, the first-stage window must hold sixteen ones, and this must last long enough for the clamped 15s to fill both later delay lines. The bench drives solid runs of ones at 16 taps with the clamp enabled and follows the sample to its 3840 plateau. A separate pattern puts exactly one zero in every 16 bits, so the count stops at 15. The same pattern then shows that the clamp leaves a non-saturating stream untouched. The start of every scenario toggles the length to force a clear, so the fill edge of the valid flag can be compared against an exact edge count.

// File: rtl/mavg_pkg.sv
package mavg_pkg;
  // Window length encoding on len_sel
  localparam logic LEN_SHORT = 1'b0;
  localparam logic LEN_LONG  = 1'b1;
endpackage

// File: rtl/mavg_rst_sync.sv
module mavg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/mavg_stage.sv
module mavg_stage #(
  parameter int IN_W   = 1,
  parameter int OUT_W  = 5,
  parameter int DEPTH  = 16,
  parameter int IN_MAX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             long_sel,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] sum_o
);
  localparam int SHORT     = DEPTH / 2;
  localparam int SUM_MAX_I = DEPTH * IN_MAX;
  localparam logic [OUT_W-1:0] SUM_MAX = OUT_W'(SUM_MAX_I);

  logic [IN_W-1:0]  dly_q [DEPTH];
  logic [IN_W-1:0]  dly_d [DEPTH];
  logic [OUT_W-1:0] sum_q;
  logic [OUT_W-1:0] sum_d;
  logic [IN_W-1:0]  leaving;

  // Value dropping out of the active window
  always_comb begin
    leaving = long_sel ? dly_q[DEPTH-1] : dly_q[SHORT-1];
  end

  // Next state: shift in, update running sum incrementally
  always_comb begin
    dly_d[0] = clr ? '0 : din;
    for (int i = 1; i < DEPTH; i++) begin
      dly_d[i] = clr ? '0 : dly_q[i-1];
    end
    if (clr) begin
      sum_d = '0;
    end else begin
      sum_d = sum_q + OUT_W'(din) - OUT_W'(leaving);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dly_q[i] <= '0;
      end
      sum_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        dly_q[i] <= dly_d[i];
      end
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

  // R3
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= SUM_MAX);

  // R6
  stage_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0));
endmodule

// File: rtl/mavg_ctrl.sv
module mavg_ctrl #(
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic len_sel,
  output logic clr_o,
  output logic long_o,
  output logic valid_o
);
  import mavg_pkg::*;

  localparam logic [CNT_W-1:0] FILL_LONG  = CNT_W'(3 * MAX_LEN);
  localparam logic [CNT_W-1:0] FILL_SHORT = CNT_W'(3 * (MAX_LEN / 2));

  logic             len_q, len_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;
  logic             clr;

  always_comb begin
    clr    = (len_sel != len_q);
    target = (len_q == LEN_LONG) ? FILL_LONG : FILL_SHORT;
    len_d  = len_sel;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q < target) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_SHORT;
      cnt_q <= '0;
    end else begin
      len_q <= len_d;
      cnt_q <= cnt_d;
    end
  end

  assign clr_o   = clr;
  assign long_o  = len_q;
  assign valid_o = (cnt_q == target);

  // R6
  clear_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid_o);

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !clr) |=> valid_o);
endmodule

// File: rtl/mavg_bitstream_filter.sv
module mavg_bitstream_filter #(
  parameter int MAX_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_i,
  input  logic        len_sel,
  input  logic        sat_en,
  output logic [12:0] sample_o,
  output logic        valid_o
);
  localparam int S1_W  = $clog2(MAX_LEN + 1);
  localparam int S2_W  = $clog2(MAX_LEN * MAX_LEN + 1);
  localparam int S3_W  = $clog2(MAX_LEN * MAX_LEN * MAX_LEN + 1);
  localparam int CNT_W = $clog2(3 * MAX_LEN + 1);
  localparam int SHORT = MAX_LEN / 2;
  localparam logic [S3_W-1:0] SHORT_FS = S3_W'(SHORT * SHORT * SHORT);
  localparam logic [S1_W-1:0] S1_CLAMP = S1_W'(MAX_LEN - 1);

  logic            rst_i_n;
  logic            clr;
  logic            long_sel;
  logic [S1_W-1:0] s1_sum;
  logic [S1_W-1:0] s1_fed;
  logic [S2_W-1:0] s2_sum;
  logic [S3_W-1:0] s3_sum;

  mavg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mavg_ctrl #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .len_sel (len_sel),
    .clr_o   (clr),
    .long_o  (long_sel),
    .valid_o (valid_o)
  );

  mavg_stage #(.IN_W(1), .OUT_W(S1_W), .DEPTH(MAX_LEN), .IN_MAX(1)) u_st1 (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (clr),
    .long_sel (long_sel),
    .din      (bit_i),
    .sum_o    (s1_sum)
  );

  // Full-scale policy: clamp count MAX_LEN to MAX_LEN-1 when enabled.
  // The clamped value is what enters stage two's delay line.
  always_comb begin
    if (sat_en && (s1_sum == S1_W'(MAX_LEN))) begin
      s1_fed = S1_CLAMP;
    end else begin
      s1_fed = s1_sum;
    end
  end

  mavg_stage #(.IN_W(S1_W), .OUT_W(S2_W), .DEPTH(MAX_LEN), .IN_MAX(MAX_LEN)) u_st2 (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (clr),
    .long_sel (long_sel),
    .din      (s1_fed),
    .sum_o    (s2_sum)
  );

  mavg_stage #(.IN_W(S2_W), .OUT_W(S3_W), .DEPTH(MAX_LEN),
               .IN_MAX(MAX_LEN * MAX_LEN)) u_st3 (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (clr),
    .long_sel (long_sel),
    .din      (s2_sum),
    .sum_o    (s3_sum)
  );

  assign sample_o = 13'(s3_sum);

  // R5
  short_scale_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (valid_o && !long_sel) |-> (s3_sum <= SHORT_FS));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_i_n |-> (sample_o == '0 && !valid_o));
endmodule

// File: tb/mavg_bitstream_filter_tb_top.sv
module mavg_bitstream_filter_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bit_i;
  logic        len_sel;
  logic        sat_en;
  logic [12:0] sample_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit hist [0:1023];
  int k_m;
  bit len_m;
  bit sat_m;

  mavg_bitstream_filter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_i    (bit_i),
    .len_sel  (len_sel),
    .sat_en   (sat_en),
    .sample_o (sample_o),
    .valid_o  (valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int win_len();
    return len_m ? 16 : 8;
  endfunction

  function automatic int s1v(int p);
    int s = 0;
    int l = win_len();
    for (int t = 0; t < l; t++) begin
      if (p - t >= 1) s += int'(hist[p - t]);
    end
    if (sat_m && s == 16) s = 15;
    return s;
  endfunction

  function automatic int expect_y();
    int y = 0;
    int l = win_len();
    for (int j = 0; j < l; j++) begin
      for (int i = 0; i < l; i++) begin
        y += s1v(k_m - 2 - j - i);
      end
    end
    return y;
  endfunction

  // One clock: drive at negedge, model at the edge, check at next negedge
  task automatic step(bit b, bit l, string req);
    int exp_v;
    bit cleared;
    bit_i   = b;
    len_sel = l;
    @(posedge clk);
    cleared = (l != len_m);
    if (cleared) begin
      len_m = l;
      k_m = 0;
      for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
    end else begin
      k_m++;
      hist[k_m] = b;
    end
    @(negedge clk);
    exp_v = (k_m >= 3 * win_len()) ? 1 : 0;
    if (cleared) begin
      chk("R6 sample after clear", int'(sample_o), 0);
      chk("R6 valid after clear", int'(valid_o), 0);
    end else begin
      chk({req, " R2/R8 sample"}, int'(sample_o), expect_y());
      chk("R7/R10 valid", int'(valid_o), exp_v);
    end
  endtask

  // Force a clear so each scenario starts from known state
  task automatic restart(bit l);
    if (len_m == l) step(1'b0, ~l, "restart");
    step(1'b0, l, "restart");
  endtask

  // mode 0: all ones, 1: random, 2: one zero every 16 bits
  function automatic bit pat(int mode, int i);
    case (mode)
      0: return 1'b1;
      1: return ($urandom % 100) < 60;
      default: return (i % 16) != 15;
    endcase
  endfunction

  task automatic do_reset();
    rst_n   = 1'b0;
    bit_i   = 1'b0;
    len_sel = 1'b0;
    sat_en  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sample in reset", int'(sample_o), 0);
    chk("R1 valid in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    len_m = 1'b0; sat_m = 1'b0; k_m = 0;
    for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
    chk("R1 sample after reset", int'(sample_o), 0);
    chk("R1 valid after reset", int'(valid_o), 0);
  endtask

  task automatic t_full_long();
    sat_en = 1'b0; sat_m = 1'b0;
    restart(1'b1);
    for (int i = 0; i < 60; i++) step(pat(0, i), 1'b1, "R3");
    chk("R3 full scale 16 taps", int'(sample_o), 4096);
  endtask

  task automatic t_sat_long();
    sat_en = 1'b1; sat_m = 1'b1;
    restart(1'b1);
    for (int i = 0; i < 60; i++) step(pat(0, i), 1'b1, "R4");
    chk("R4 clamped full scale", int'(sample_o), 3840);
  endtask

  task automatic t_full_short();
    sat_en = 1'b1; sat_m = 1'b1;
    restart(1'b0);
    for (int i = 0; i < 40; i++) step(pat(0, i), 1'b0, "R5");
    chk("R5 full scale 8 taps", int'(sample_o), 512);
  endtask

  task automatic t_random(bit l, bit s);
    sat_en = s; sat_m = s;
    restart(l);
    for (int i = 0; i < 150; i++) step(pat(1, i), l, "R2 random");
  endtask

  task automatic t_no_clamp_effect();
    // DUT clamps, model does not: counts never reach 16
    sat_en = 1'b1; sat_m = 1'b0;
    restart(1'b1);
    for (int i = 0; i < 120; i++) step(pat(2, i), 1'b1, "R9");
    chk("R9 steady 15-of-16 level", int'(sample_o), 3840);
  endtask

  task automatic t_len_switch();
    sat_en = 1'b0; sat_m = 1'b0;
    restart(1'b1);
    for (int i = 0; i < 70; i++) step(pat(1, i), 1'b1, "R10 hold");
    step(1'b1, 1'b0, "R6 switch");
    for (int i = 0; i < 30; i++) step(pat(0, i), 1'b0, "R7 refill");
  endtask

  initial begin
    do_reset();
    t_full_long();
    t_sat_long();
    t_full_short();
    t_random(1'b1, 1'b0);
    t_random(1'b0, 1'b0);
    t_random(1'b1, 1'b1);
    t_no_clamp_effect();
    t_len_switch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule